// File: doc/BRIEF.md
# Start-Delimiter Aligner and 5B/4B Symbol Decoder

This block sits after the descrambler in a 100 Mb/s receive path. It takes one descrambled bit per clock, with no knowledge of where 5-bit code groups begin. It watches the stream for the start-of-stream delimiter pair. The pair is the 10-bit pattern `11000` `10001`, and it only counts when a run of idle ones comes before it. When the block finds the pair, it fixes the code-group boundary at that point and raises its packet-active flag.

From that point on, every fifth bit closes a symbol. The block maps each symbol to a 4-bit nibble and reports it with a one-cycle data-valid strobe. The delimiter pair itself is reported as two preamble nibbles. The packet closes cleanly on the end-of-stream pair `01101` `00111`. It closes with an error if two idle codes arrive back to back. Any code that is not a data code raises the error flag.

Each decoded symbol waits in a one-symbol hold slot before it is reported. This lets the block tell a lone end-of-stream symbol apart from a complete end-of-stream pair.

Top module: `jk_nibble_decoder`

## Requirements
- R1: The stream bit `rx_bit` enters a shift window, first-received bit in the most significant position of each 5-bit code. The start pair `1100010001` is accepted only while searching, and only if the IDLE_RUN (default 10) bits received just before it are all ones. `rx_act` rises on the clock edge that samples the final bit of the pair.
- R2: A start pair whose preceding IDLE_RUN bits contain any zero is ignored. No `rx_dv`, no `rx_err` and no `rx_act` result, even for the symbols that follow it.
- R3: The start pair is reported as two preamble nibbles of value `0101`. The first has `rx_dv` high on the same edge that raises `rx_act`. The second follows exactly five clocks later.
- R4: Inside a packet, each group of five bits after the start pair forms one symbol. Every data code is reported with `rx_dv` high and `rx_err` low. The codes, nibble 0 through F, are: 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101. Consecutive reported nibbles of a plain data packet are exactly five clocks apart, in order.
- R5: The symbol `01101` followed directly by `00111` ends the packet. Neither symbol produces a nibble. `rx_act` is low on the edge that samples the last bit of `00111`, and the block searches for a new start pair again.
- R6: A code that is neither a data code nor `01101`/`11111` is reported with `rx_dv` and `rx_err` both high and `rx_nib` = 0. This covers `00000`, a start code inside a packet, and `00111` not preceded by `01101`.
- R7: Two consecutive `11111` symbols inside a packet end it. On the second one, `rx_err` pulses high with `rx_dv` low, and `rx_act` drops on that same edge.
- R8: A lone `01101` not followed by `00111`, or a lone `11111` not followed by another `11111`, is reported as an error nibble (`rx_dv`=1, `rx_err`=1, `rx_nib`=0). The symbol after it is then decoded normally.
- R9: `rx_dv` is never high while `rx_act` is low, and never high on two consecutive clocks.
- R10: During and right after synchronous reset `rst`, `rx_dv`, `rx_err`, `rx_act` and `rx_nib` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one stream bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Descrambled, unaligned serial stream bit |
| rx_nib | output | 4 | Decoded nibble; zero on error reports |
| rx_dv | output | 1 | One-cycle strobe marking a reported nibble |
| rx_err | output | 1 | One-cycle code or framing error flag |
| rx_act | output | 1 | High from start pair until the packet ends |

## Verification
Each symbol boundary can do two jobs on the same edge. It flushes the symbol held from the previous boundary, and it may also decide that the packet has ended, either from an end pair or from a double idle. The bench provokes this in three ways: end pairs closing random-length packets, lone end and idle symbols followed by data, and idle pairs inside a packet. For each case it builds the exact ordered list of reported nibbles and errors from the symbols it sent, and compares it against what appears at the outputs. It also samples `rx_act` at the edge that closes each end symbol, to judge whether the flush and the close resolved correctly.

// File: rtl/pcs_rx_pkg.sv
package pcs_rx_pkg;
    localparam int SYM_W = 5;
    localparam int NIB_W = 4;
    localparam int PAIR_W = 2 * SYM_W;

    localparam logic [PAIR_W-1:0] START_PAIR = 10'b11000_10001;
    localparam logic [SYM_W-1:0]  CODE_END1  = 5'b01101;
    localparam logic [SYM_W-1:0]  CODE_END2  = 5'b00111;
    localparam logic [SYM_W-1:0]  CODE_IDLE  = 5'b11111;
    localparam logic [NIB_W-1:0]  PRE_NIB    = 4'b0101;

    typedef enum logic [2:0] {
        SK_NONE,
        SK_DATA,
        SK_END1,
        SK_IDLE,
        SK_BAD
    } sym_kind_e;

    typedef struct packed {
        sym_kind_e        kind;
        logic [NIB_W-1:0] nib;
    } sym_t;

    typedef enum logic {
        ST_HUNT,
        ST_FRAME
    } rx_state_e;

    function automatic sym_t classify(input logic [SYM_W-1:0] code);
        sym_t s;
        s.kind = SK_DATA;
        s.nib  = '0;
        case (code)
            5'b11110: s.nib = 4'h0;
            5'b01001: s.nib = 4'h1;
            5'b10100: s.nib = 4'h2;
            5'b10101: s.nib = 4'h3;
            5'b01010: s.nib = 4'h4;
            5'b01011: s.nib = 4'h5;
            5'b01110: s.nib = 4'h6;
            5'b01111: s.nib = 4'h7;
            5'b10010: s.nib = 4'h8;
            5'b10011: s.nib = 4'h9;
            5'b10110: s.nib = 4'hA;
            5'b10111: s.nib = 4'hB;
            5'b11010: s.nib = 4'hC;
            5'b11011: s.nib = 4'hD;
            5'b11100: s.nib = 4'hE;
            5'b11101: s.nib = 4'hF;
            CODE_END1: s.kind = SK_END1;
            CODE_IDLE: s.kind = SK_IDLE;
            default:   s.kind = SK_BAD;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/pcs_rx_window.sv
module pcs_rx_window
    import pcs_rx_pkg::*;
#(
    parameter int IDLE_RUN = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_in,
    output logic [SYM_W-1:0] sym_code,
    output logic             start_hit
);
    localparam int WIN_W = PAIR_W + IDLE_RUN;

    logic [WIN_W-1:0] win_q;
    logic [WIN_W-1:0] win_nx;

    assign win_nx = {win_q[WIN_W-2:0], bit_in};

    always_ff @(posedge clk) begin
        if (rst) win_q <= '0;
        else     win_q <= win_nx;
    end

    assign sym_code  = win_nx[SYM_W-1:0];
    assign start_hit = (win_nx[PAIR_W-1:0] == START_PAIR) &&
                       (&win_nx[WIN_W-1:PAIR_W]);
endmodule

// File: rtl/pcs_rx_symdec.sv
module pcs_rx_symdec
    import pcs_rx_pkg::*;
(
    input  logic [SYM_W-1:0] code,
    output sym_t             sym
);
    always_comb sym = classify(code);
endmodule

// File: rtl/jk_nibble_decoder.sv
module jk_nibble_decoder
    import pcs_rx_pkg::*;
#(
    parameter int IDLE_RUN = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_bit,
    output logic [3:0] rx_nib,
    output logic       rx_dv,
    output logic       rx_err,
    output logic       rx_act
);
    localparam int PH_W = $clog2(SYM_W);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(SYM_W - 1);

    logic [SYM_W-1:0] sym_code;
    logic             start_hit;
    sym_t             cur;
    sym_t             held;
    rx_state_e        st;
    logic [PH_W-1:0]  phase;

    pcs_rx_window #(.IDLE_RUN(IDLE_RUN)) u_win (
        .clk       (clk),
        .rst       (rst),
        .bit_in    (rx_bit),
        .sym_code  (sym_code),
        .start_hit (start_hit)
    );

    pcs_rx_symdec u_dec (
        .code (sym_code),
        .sym  (cur)
    );

    logic end_pair;
    logic end_idle;
    assign end_pair = (held.kind == SK_END1) && (sym_code == CODE_END2);
    assign end_idle = (held.kind == SK_IDLE) && (cur.kind == SK_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_HUNT;
            phase  <= '0;
            held   <= '{kind: SK_NONE, nib: '0};
            rx_nib <= '0;
            rx_dv  <= 1'b0;
            rx_err <= 1'b0;
            rx_act <= 1'b0;
        end else begin
            rx_nib <= '0;
            rx_dv  <= 1'b0;
            rx_err <= 1'b0;
            case (st)
                ST_HUNT: begin
                    if (start_hit) begin
                        st     <= ST_FRAME;
                        phase  <= '0;
                        held   <= '{kind: SK_DATA, nib: PRE_NIB};
                        rx_nib <= PRE_NIB;
                        rx_dv  <= 1'b1;
                        rx_act <= 1'b1;
                    end
                end
                default: begin
                    if (phase != PH_LAST) begin
                        phase <= phase + 1'b1;
                    end else begin
                        phase <= '0;
                        if (end_pair) begin
                            st     <= ST_HUNT;
                            rx_act <= 1'b0;
                            held   <= '{kind: SK_NONE, nib: '0};
                        end else if (end_idle) begin
                            st     <= ST_HUNT;
                            rx_act <= 1'b0;
                            rx_err <= 1'b1;
                            held   <= '{kind: SK_NONE, nib: '0};
                        end else begin
                            case (held.kind)
                                SK_DATA: begin
                                    rx_dv  <= 1'b1;
                                    rx_nib <= held.nib;
                                end
                                SK_NONE: ;
                                default: begin
                                    rx_dv  <= 1'b1;
                                    rx_err <= 1'b1;
                                end
                            endcase
                            held <= cur;
                        end
                    end
                end
            endcase
        end
    end

    AST_START_PREAMBLE: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_act) |-> (rx_dv && rx_nib == PRE_NIB && !rx_err)); // R3
    AST_DV_INSIDE_PKT: assert property (@(posedge clk) disable iff (rst)
        rx_dv |-> rx_act); // R9
    AST_DV_NOT_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        rx_dv |=> !rx_dv); // R9
    AST_END_NO_NIBBLE: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_act) |-> !rx_dv); // R5
    AST_ERR_NIB_ZERO: assert property (@(posedge clk) disable iff (rst)
        rx_err |-> (rx_nib == '0)); // R6
    AST_HUNT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HUNT && !start_hit) |=> (!rx_dv && !rx_act)); // R2
endmodule

// File: tb/sim_jk_nibble_decoder.sv
`timescale 1ns/100ps
module sim_jk_nibble_decoder;
    logic       clk = 1'b0;
    logic       rst;
    logic       rx_bit;
    logic [3:0] rx_nib;
    logic       rx_dv;
    logic       rx_err;
    logic       rx_act;

    always #2.5 clk = ~clk;

    jk_nibble_decoder u0 (
        .clk(clk), .rst(rst), .rx_bit(rx_bit),
        .rx_nib(rx_nib), .rx_dv(rx_dv), .rx_err(rx_err), .rx_act(rx_act)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int last_dv_cyc = -1;
    logic strict_gap = 1'b0;
    logic act_seen = 1'b0;
    logic [5:0] exp_q[$];
    logic [5:0] obs_q[$];

    localparam logic [4:0] S_J = 5'b11000, S_K = 5'b10001;
    localparam logic [4:0] S_T = 5'b01101, S_R = 5'b00111, S_I = 5'b11111;
    localparam logic [5:0] EV_BAD = 6'b11_0000;
    localparam logic [5:0] EV_PRE = 6'b10_0101;

    function automatic logic [4:0] enc(input logic [3:0] n);
        case (n)
            4'h0: return 5'b11110; 4'h1: return 5'b01001;
            4'h2: return 5'b10100; 4'h3: return 5'b10101;
            4'h4: return 5'b01010; 4'h5: return 5'b01011;
            4'h6: return 5'b01110; 4'h7: return 5'b01111;
            4'h8: return 5'b10010; 4'h9: return 5'b10011;
            4'hA: return 5'b10110; 4'hB: return 5'b10111;
            4'hC: return 5'b11010; 4'hD: return 5'b11011;
            4'hE: return 5'b11100; default: return 5'b11101;
        endcase
    endfunction

    function automatic logic [5:0] ev_data(input logic [3:0] n);
        return {2'b10, n};
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input int actv, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, actv, expv);
        end
    endtask

    task automatic send_bit(input logic b);
        rx_bit = b;
        @(negedge clk);
        cyc++;
        if (rx_act) act_seen = 1'b1;
        if (rx_dv || rx_err)
            obs_q.push_back({rx_dv, rx_err, rx_dv ? rx_nib : 4'h0});
        if (rx_dv) begin
            check(rx_act, "R9", "dv without act", 0, 1);
            if (strict_gap && last_dv_cyc >= 0)
                check(cyc - last_dv_cyc == 5, "R4", "dv spacing", cyc - last_dv_cyc, 5);
            last_dv_cyc = cyc;
        end
        if (!rx_act) last_dv_cyc = -1;
    endtask

    task automatic send_sym(input logic [4:0] c);
        for (int i = 4; i >= 0; i--) send_bit(c[i]);
    endtask

    task automatic send_idle(input int n);
        for (int i = 0; i < n; i++) send_sym(S_I);
    endtask

    task automatic compare(input string req);
        check(obs_q.size() == exp_q.size(), req, "event count", obs_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < obs_q.size(); i++)
            check(obs_q[i] == exp_q[i], req, "event value", obs_q[i], exp_q[i]);
        obs_q.delete();
        exp_q.delete();
    endtask

    initial begin : watchdog
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [3:0] n;
        int len;
        void'($urandom(32'd2024));
        rst = 1'b1;
        rx_bit = 1'b1;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(rx_dv == 0 && rx_err == 0, "R10", "dv/err in reset", {rx_dv, rx_err}, 0);
        check(rx_act == 0 && rx_nib == 0, "R10", "act/nib in reset", {rx_act, rx_nib}, 0);
        rst = 1'b0;

        // R1 R3 R4 R5: directed packet with exact timing
        send_idle(3);
        send_sym(S_J);
        send_sym(S_K);
        check(rx_act == 1, "R1", "act after start pair", rx_act, 1);
        check(rx_dv == 1 && rx_nib == 4'h5, "R3", "first preamble", {rx_dv, rx_nib}, 5'h15);
        exp_q.push_back(EV_PRE);
        exp_q.push_back(EV_PRE);
        strict_gap = 1'b1;
        for (int i = 0; i < 16; i++) begin
            send_sym(enc(4'(i)));
            exp_q.push_back(ev_data(4'(i)));
        end
        send_sym(S_T);
        check(rx_act == 1, "R5", "act after lone end1", rx_act, 1);
        send_sym(S_R);
        check(rx_act == 0, "R5", "act after end pair", rx_act, 0);
        strict_gap = 1'b0;
        send_idle(2);
        compare("R4");

        // R2: start pair without preceding idle run
        act_seen = 1'b0;
        send_sym(5'b00000);
        send_sym(S_J);
        send_sym(S_K);
        send_sym(enc(4'h3));
        send_sym(S_T);
        send_sym(S_R);
        send_idle(1);
        check(act_seen == 0, "R2", "act without idle run", act_seen, 0);
        compare("R2");

        // R6: invalid codes inside a packet
        send_idle(3);
        send_sym(S_J); send_sym(S_K);
        exp_q.push_back(EV_PRE); exp_q.push_back(EV_PRE);
        send_sym(enc(4'hA)); exp_q.push_back(ev_data(4'hA));
        send_sym(5'b00000);  exp_q.push_back(EV_BAD);
        send_sym(S_J);       exp_q.push_back(EV_BAD);
        send_sym(S_R);       exp_q.push_back(EV_BAD);
        send_sym(enc(4'h7)); exp_q.push_back(ev_data(4'h7));
        send_sym(S_T); send_sym(S_R);
        check(rx_act == 0, "R6", "act after end pair", rx_act, 0);
        send_idle(2);
        compare("R6");

        // R7: idle pair inside a packet
        send_idle(2);
        send_sym(S_J); send_sym(S_K);
        exp_q.push_back(EV_PRE); exp_q.push_back(EV_PRE);
        send_sym(enc(4'h2)); exp_q.push_back(ev_data(4'h2));
        send_sym(enc(4'hE)); exp_q.push_back(ev_data(4'hE));
        send_sym(S_I);
        check(rx_act == 1, "R7", "act after one idle", rx_act, 1);
        send_sym(S_I);
        check(rx_err == 1 && rx_dv == 0, "R7", "err pulse on idle pair", {rx_dv, rx_err}, 1);
        check(rx_act == 0, "R7", "act after idle pair", rx_act, 0);
        exp_q.push_back(6'b01_0000);
        send_idle(2);
        compare("R7");

        // R8: lone end1 and lone idle
        send_idle(2);
        send_sym(S_J); send_sym(S_K);
        exp_q.push_back(EV_PRE); exp_q.push_back(EV_PRE);
        send_sym(enc(4'h1)); exp_q.push_back(ev_data(4'h1));
        send_sym(S_T);       exp_q.push_back(EV_BAD);
        send_sym(enc(4'h9)); exp_q.push_back(ev_data(4'h9));
        send_sym(S_I);       exp_q.push_back(EV_BAD);
        send_sym(enc(4'hC)); exp_q.push_back(ev_data(4'hC));
        send_sym(S_T); send_sym(S_R);
        check(rx_act == 0, "R8", "act after end pair", rx_act, 0);
        send_idle(2);
        compare("R8");

        // R4 R5 R1: random packets, random bit offsets
        for (int p = 0; p < 30; p++) begin
            for (int k = 0; k < int'($urandom_range(4, 0)); k++) send_bit(1'b1);
            send_idle(2);
            send_sym(S_J); send_sym(S_K);
            check(rx_act == 1, "R1", "act at random start", rx_act, 1);
            exp_q.push_back(EV_PRE); exp_q.push_back(EV_PRE);
            strict_gap = 1'b1;
            len = int'($urandom_range(40, 1));
            for (int i = 0; i < len; i++) begin
                n = 4'($urandom_range(15, 0));
                send_sym(enc(n));
                exp_q.push_back(ev_data(n));
            end
            send_sym(S_T); send_sym(S_R);
            strict_gap = 1'b0;
            check(rx_act == 0, "R5", "act at random end", rx_act, 0);
            send_idle(1);
            compare("R4");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule